// File: doc/BRIEF.md
# Processor Power-Down Controller

This block keeps track of whether an 8-bit processor core is allowed to clock its internal logic, or is parked in a low-power state. The core can reach that state in two ways. It can execute a HALT instruction. It can also be asked to give up its bus through a hold request while it is running any other instruction. The block records which of the two happened, because each way has its own way out.

After a HALT, only reset or a recognized interrupt brings the core back. Dropping a hold request has no effect on it. After a hold, only reset or the removal of the hold request brings the core back, and interrupts are ignored.

The hold request and the five interrupt-recognized lines first pass through a chain of synchronizing flops clocked by the free-running controller clock. The HALT strobe already comes from the core's own clock domain and is used directly. The outputs are all registered:

- a clock enable for the core;
- a two-bit code giving the cause of the power-down;
- the hold acknowledge.

Top module: `pd_ctrl`

## Requirements
- R1: A synchronous active-high reset drives the state to running within one clock edge, from any state. After that edge `pd_cause` is 2'b00, `core_clk_en` is 1 and `bus_grant` is 0. Reset also clears the synchronizer flops.
- R2: `bus_req` and `wake_evt` are seen only after SYNC_STAGES synchronizing flops. A change at these inputs before edge k can alter the state no earlier than edge k+SYNC_STAGES.
- R3: In the running state, a high `halt_exec` at a clock edge moves the block to the halt power-down state at that edge. `pd_cause` then reads 2'b01 and `core_clk_en` reads 0.
- R4: In the running state, a high synchronized hold request moves the block to the hold power-down state. `pd_cause` then reads 2'b10 and `core_clk_en` reads 0.
- R5: If `halt_exec` and the synchronized hold request are both high while running, the halt power-down state (2'b01) is entered.
- R6: The halt power-down state returns to running (2'b00) when any bit of the synchronized `wake_evt` is high. Bit 4 is TRAP, bit 3 is RST7.5, bit 2 is RST6.5, bit 1 is RST5.5 and bit 0 is INTR.
- R7: In the halt power-down state, raising or dropping `bus_req` leaves `pd_cause` at 2'b01.
- R8: The hold power-down state returns to running when the synchronized hold request is low.
- R9: In the hold power-down state, pulses on any `wake_evt` bit leave `pd_cause` at 2'b10.
- R10: `bus_grant` equals the synchronized hold request delayed by one edge, whatever the power-down state.
- R11: `core_clk_en` is 1 exactly when `pd_cause` is 2'b00.
- R12: `halt_exec` is ignored in either power-down state, and `wake_evt` is ignored while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_exec | input | 1 | One-cycle strobe: the core executed HALT |
| bus_req | input | 1 | Hold request from another bus master (asynchronous) |
| wake_evt | input | NUM_WAKE | Interrupt-recognized lines; bit 4 TRAP, 3 RST7.5, 2 RST6.5, 1 RST5.5, 0 INTR |
| core_clk_en | output | 1 | Core clock enable, low while powered down |
| pd_cause | output | 2 | 00 running, 01 halt power-down, 10 hold power-down |
| bus_grant | output | 1 | Hold acknowledge |

## Verification
A state register that forgot its entry cause would show up within SYNC_STAGES+1 edges. One symptom is a halted core that wakes when `bus_req` falls. The other is a held core that wakes on an interrupt pulse. Either way `pd_cause` and `core_clk_en` would flip at a moment the bench did not predict.

An illegal code or a clock enable out of step with the cause is visible on the very next edge. A synchronizer chain of the wrong length moves every wake edge by one or more cycles. The bench samples one edge before and one edge after each predicted change, so such a shift is caught.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_RUN    = 2'b00,
    PD_HALTED = 2'b01,
    PD_HELD   = 2'b10
  } pd_state_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pd_wake_merge.sv
module pd_wake_merge #(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] lines,
  output logic             any
);
  assign any = |lines;
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      halt_exec,
  input  logic      hold_s,
  input  logic      wake_any,
  output pd_state_e state,
  output logic      clk_en,
  output logic      grant
);
  pd_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PD_RUN: begin
        if (halt_exec)   nxt = PD_HALTED;
        else if (hold_s) nxt = PD_HELD;
      end
      PD_HALTED: if (wake_any) nxt = PD_RUN;
      PD_HELD:   if (!hold_s)  nxt = PD_RUN;
      default:   nxt = PD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PD_RUN;
      clk_en <= 1'b1;
      grant  <= 1'b0;
    end else begin
      state  <= nxt;
      clk_en <= (nxt == PD_RUN);
      grant  <= hold_s;
    end
  end
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_pkg::*;
#(
  parameter int NUM_WAKE    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                halt_exec,
  input  logic                bus_req,
  input  logic [NUM_WAKE-1:0] wake_evt,
  output logic                core_clk_en,
  output logic [1:0]          pd_cause,
  output logic                bus_grant
);
  localparam int SYNC_W = NUM_WAKE + 1;

  logic [SYNC_W-1:0]   sync_q;
  logic                hold_s;
  logic [NUM_WAKE-1:0] wake_s;
  logic                wake_any;
  pd_state_e           state;

  pd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_req, wake_evt}),
    .q   (sync_q)
  );

  assign hold_s = sync_q[SYNC_W-1];
  assign wake_s = sync_q[NUM_WAKE-1:0];

  pd_wake_merge #(.WIDTH(NUM_WAKE)) u_merge (
    .lines (wake_s),
    .any   (wake_any)
  );

  pd_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .halt_exec (halt_exec),
    .hold_s    (hold_s),
    .wake_any  (wake_any),
    .state     (state),
    .clk_en    (core_clk_en),
    .grant     (bus_grant)
  );

  assign pd_cause = state;
endmodule

// File: rtl/pd_ctrl_chk.sv
module pd_ctrl_chk
  import pd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       halt_exec,
  input logic [1:0] pd_cause,
  input logic       core_clk_en,
  input logic       bus_grant,
  input logic       hold_s,
  input logic       wake_any
);
  assert_reset_run_R1: assert property (@(posedge clk)
    rst |=> (pd_cause == PD_RUN && core_clk_en && !bus_grant));

  assert_halt_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == PD_RUN && halt_exec) |=> pd_cause == PD_HALTED);

  assert_hold_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == PD_RUN && !halt_exec && hold_s) |=> pd_cause == PD_HELD);

  assert_halt_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == PD_HALTED && !wake_any) |=> pd_cause == PD_HALTED);

  assert_halt_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == PD_HALTED && wake_any) |=> pd_cause == PD_RUN);

  assert_hold_stays_R9: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == PD_HELD && hold_s) |=> pd_cause == PD_HELD);

  assert_hold_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == PD_HELD && !hold_s) |=> pd_cause == PD_RUN);

  assert_grant_follow_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> bus_grant == $past(hold_s));

  assert_clk_en_R11: assert property (@(posedge clk) disable iff (rst)
    core_clk_en == (pd_cause == PD_RUN));

  assert_legal_code_R11: assert property (@(posedge clk) disable iff (rst)
    pd_cause != 2'b11);
endmodule

bind pd_ctrl pd_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .halt_exec   (halt_exec),
  .pd_cause    (pd_cause),
  .core_clk_en (core_clk_en),
  .bus_grant   (bus_grant),
  .hold_s      (hold_s),
  .wake_any    (wake_any)
);

// File: tb/sim_pd_ctrl.sv
module sim_pd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NW   = 5;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          halt_exec;
  logic          bus_req;
  logic [NW-1:0] wake_evt;
  logic          core_clk_en;
  logic [1:0]    pd_cause;
  logic          bus_grant;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_ctrl #(.NUM_WAKE(NW), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .halt_exec(halt_exec), .bus_req(bus_req),
    .wake_evt(wake_evt), .core_clk_en(core_clk_en), .pd_cause(pd_cause),
    .bus_grant(bus_grant)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_state(string tag, int exp_cause);
    chk({tag, " cause"}, pd_cause, exp_cause);
    chk({tag, " clk_en R11"}, core_clk_en, (exp_cause == 0) ? 1 : 0);
  endtask

  task automatic enter_halt();
    halt_exec = 1'b1; tick(1); halt_exec = 1'b0;
  endtask

  task automatic pulse_wake(int bit_i);
    wake_evt[bit_i] = 1'b1; tick(1); wake_evt = '0;
  endtask

  initial begin
    rst = 1'b1; halt_exec = 1'b0; bus_req = 1'b0; wake_evt = '0;
    tick(3);
    rst = 1'b0;
    chk_state("R1 reset", 0);
    chk("R1 grant", bus_grant, 0);

    // R12: interrupts while running do nothing
    pulse_wake(4); tick(SYNC + 2);
    chk_state("R12 wake in run", 0);

    for (int i = 0; i < NW; i++) begin
      enter_halt();
      chk_state("R3 halt entry", 1);
      enter_halt();
      chk_state("R12 halt while halted", 1);
      pulse_wake(i); tick(SYNC - 1);
      chk_state("R2 wake before sync", 1);
      tick(1);
      chk_state("R6 wake from halt", 0);
    end

    // R7: hold request toggling does not release halt
    enter_halt();
    bus_req = 1'b1; tick(SYNC + 1);
    chk("R10 grant up", bus_grant, 1);
    chk_state("R7 hold up in halt", 1);
    bus_req = 1'b0; tick(SYNC + 2);
    chk("R10 grant down", bus_grant, 0);
    chk_state("R7 hold down in halt", 1);
    pulse_wake(0); tick(SYNC);
    chk_state("R6 exit after R7", 0);

    for (int i = 0; i < NW; i++) begin
      bus_req = 1'b1; tick(SYNC);
      chk_state("R2 hold before sync", 0);
      tick(1);
      chk_state("R4 hold entry", 2);
      chk("R10 grant", bus_grant, 1);
      pulse_wake(i); tick(SYNC + 2);
      chk_state("R9 wake in hold", 2);
      enter_halt(); tick(1);
      chk_state("R12 halt in hold", 2);
      bus_req = 1'b0; tick(SYNC);
      chk_state("R8 before release", 2);
      tick(1);
      chk_state("R8 hold release", 0);
      chk("R10 grant release", bus_grant, 0);
    end

    // R5: halt and synchronized hold in the same cycle
    bus_req = 1'b1; tick(SYNC);
    enter_halt();
    chk_state("R5 halt wins", 1);
    bus_req = 1'b0; tick(SYNC + 2);
    chk_state("R5 R7 still halted", 1);
    pulse_wake(3); tick(SYNC);
    chk_state("R6 exit after R5", 0);

    // R1: reset releases both kinds of power-down
    enter_halt();
    rst = 1'b1; tick(1); rst = 1'b0;
    chk_state("R1 reset from halt", 0);
    bus_req = 1'b1; tick(SYNC + 1);
    chk_state("R4 hold again", 2);
    bus_req = 1'b0; rst = 1'b1; tick(1); rst = 1'b0;
    chk_state("R1 reset from hold", 0);
    chk("R1 grant cleared", bus_grant, 0);
    tick(SYNC + 2);
    chk_state("R1 stays run", 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule